// File: doc/BRIEF.md
# PHY Power-Up and Lock Sequencer

This block brings a serial-link PHY out of its powered-down state once the PHY has been configured. After a start request it first clears its three control lines. It then raises them one at a time, each a programmed number of microsecond ticks after the one before. The order is clock enable, then power (leaving shutdown), then reset release. A line that has been raised stays high until the sequence ends.

After the last line is released, the block waits a long settle interval. It then samples the PHY status word on every tick. Two status bits count as success: the PLL-lock flag and the clock-lane stop-state flag. If either is set when a sample is taken, the block reports ready. If a bounded number of samples all fail, it reports a timeout. An abort input drops every line at once, from any state.

Time is measured only in strobes on `tick_i`. The strobe is one clock wide and is normally one microsecond apart. The FSM states are IDLE, CLR, EN_CLK, UNSHUT, UNRST, SETTLE, POLL, READY and TIMEOUT, and the transitions are:

| From | To | Condition |
|------|----|-----------|
| IDLE, READY or TIMEOUT | CLR | start |
| CLR | EN_CLK | always, after one cycle |
| EN_CLK | UNSHUT | STEP_TICKS ticks have passed |
| UNSHUT | UNRST | STEP_TICKS ticks have passed |
| UNRST | SETTLE | always, after one cycle |
| SETTLE | POLL | SETTLE_TICKS ticks have passed |
| POLL | READY | a tick finds the status hit |
| POLL | TIMEOUT | POLL_LIMIT ticks have all missed |
| any state | IDLE | abort |

Top module: `phy_pwrup_seq`

## Requirements
- R1: After reset, all five outputs are low.
- R2: A start pulse in IDLE, READY or TIMEOUT drives all three control lines low in the next cycle (CLR). One cycle later only `phy_clk_en_o` is high.
- R3: `phy_power_o` rises exactly STEP_TICKS ticks after `phy_clk_en_o`, and `phy_clk_en_o` stays high.
- R4: `phy_release_o` rises STEP_TICKS ticks after `phy_power_o`. Every raised line stays high, so `phy_release_o` implies `phy_power_o`, which implies `phy_clk_en_o`.
- R5: The status word is not sampled during the SETTLE_TICKS ticks that follow the reset release.
- R6: During polling, the status word is sampled on each tick. Ready rises when bit 0 (lock) or bit 2 (clock-lane stop) is set. Bits 1 and 3 have no effect.
- R7: After POLL_LIMIT ticks with no hit, `timeout_o` rises. `ready_o` and `timeout_o` are never high together.
- R8: Abort returns all outputs to low in the next cycle, from any state. Abort takes priority over start.
- R9: A start pulse while the sequence is in progress (CLR to POLL) is ignored.
- R10: In READY and TIMEOUT, all three control lines stay high until a start or an abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or restart the power-up sequence |
| abort_i | input | 1 | Drop all lines and return to idle |
| tick_i | input | 1 | One-cycle microsecond strobe |
| phy_status_i | input | STAT_W | PHY status word (bit 0 lock, bit 2 clock-lane stop) |
| phy_clk_en_o | output | 1 | PHY clock enable |
| phy_power_o | output | 1 | PHY out of shutdown (active high) |
| phy_release_o | output | 1 | PHY reset released (active high) |
| ready_o | output | 1 | PHY reported lock or stop state |
| timeout_o | output | 1 | Polling exhausted without success |

## Verification
The bench sweeps all sixteen status words through a full sequence. A detector that decoded the wrong bit positions, or that let bits 1 and 3 count as success, would report ready or timeout wrongly for some of those words.

The bench also sweeps the tick on which a status hit first arrives, from the first poll to one past the last allowed poll. An off-by-one in the retry counter would turn the last valid hit into a timeout, or a late hit into a ready.

Each release step is probed exactly at its expiry tick, and the settle interval is probed with a status hit already present. A delay counted one tick short would show a line, or ready, one tick early.

Abort is applied in mid-sequence, and start is applied during the settle wait. A design that ignored abort would leave lines high. A design that restarted while busy would drop the lines to zero.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,
        S_CLR     = 4'd1,
        S_EN_CLK  = 4'd2,
        S_UNSHUT  = 4'd3,
        S_UNRST   = 4'd4,
        S_SETTLE  = 4'd5,
        S_POLL    = 4'd6,
        S_READY   = 4'd7,
        S_TIMEOUT = 4'd8
    } seq_state_t;

    typedef struct packed {
        logic clk_en;
        logic power;
        logic release_n;
        logic ready;
        logic timeout;
    } seq_out_t;
endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/phy_seq_status.sv
module phy_seq_status #(
    parameter int STAT_W   = 4,
    parameter int LOCK_POS = 0,
    parameter int STOP_POS = 2
) (
    input  logic [STAT_W-1:0] status,
    output logic              hit
);
    localparam logic [STAT_W-1:0] HIT_MASK =
        (STAT_W'(1) << LOCK_POS) | (STAT_W'(1) << STOP_POS);

    assign hit = |(status & HIT_MASK);
endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
    import phy_seq_pkg::*;
#(
    parameter int STAT_W       = 4,
    parameter int LOCK_POS     = 0,
    parameter int STOP_POS     = 2,
    parameter int STEP_TICKS   = 1,
    parameter int SETTLE_TICKS = 1000,
    parameter int POLL_LIMIT   = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              tick_i,
    input  logic [STAT_W-1:0] phy_status_i,
    output logic              phy_clk_en_o,
    output logic              phy_power_o,
    output logic              phy_release_o,
    output logic              ready_o,
    output logic              timeout_o
);
    localparam int MAX_DLY = (SETTLE_TICKS > STEP_TICKS) ? SETTLE_TICKS : STEP_TICKS;
    localparam int TMR_W   = $clog2(MAX_DLY + 1);
    localparam int POLL_W  = $clog2(POLL_LIMIT + 1);
    localparam logic [TMR_W-1:0]  STEP_V   = TMR_W'(STEP_TICKS);
    localparam logic [TMR_W-1:0]  SETTLE_V = TMR_W'(SETTLE_TICKS);
    localparam logic [POLL_W-1:0] POLL_MAX = POLL_W'(POLL_LIMIT - 1);

    seq_state_t        state_q, state_d;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              stat_hit;
    logic [POLL_W-1:0] tries_q;
    seq_out_t          outs;

    phy_seq_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tick_i),
        .expired  (tmr_done)
    );

    phy_seq_status #(.STAT_W(STAT_W), .LOCK_POS(LOCK_POS), .STOP_POS(STOP_POS)) u_status (
        .status (phy_status_i),
        .hit    (stat_hit)
    );

    // Next state and timer load
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = STEP_V;
        if (abort_i) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE, S_READY, S_TIMEOUT: begin
                    if (start_i) state_d = S_CLR;
                end
                S_CLR: begin
                    state_d  = S_EN_CLK;
                    tmr_load = 1'b1;
                end
                S_EN_CLK: begin
                    if (tmr_done) begin
                        state_d  = S_UNSHUT;
                        tmr_load = 1'b1;
                    end
                end
                S_UNSHUT: begin
                    if (tmr_done) state_d = S_UNRST;
                end
                S_UNRST: begin
                    state_d  = S_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_V;
                end
                S_SETTLE: begin
                    if (tmr_done) state_d = S_POLL;
                end
                S_POLL: begin
                    if (tick_i) begin
                        if (stat_hit)                  state_d = S_READY;
                        else if (tries_q == POLL_MAX)  state_d = S_TIMEOUT;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // State register and poll attempt counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            tries_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != S_POLL)  tries_q <= '0;
            else if (tick_i)        tries_q <= tries_q + 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        outs = '0;
        unique case (state_q)
            S_IDLE, S_CLR: outs = '0;
            S_EN_CLK:      outs.clk_en = 1'b1;
            S_UNSHUT: begin
                outs.clk_en = 1'b1;
                outs.power  = 1'b1;
            end
            S_UNRST, S_SETTLE, S_POLL, S_READY, S_TIMEOUT: begin
                outs.clk_en    = 1'b1;
                outs.power     = 1'b1;
                outs.release_n = 1'b1;
                outs.ready     = (state_q == S_READY);
                outs.timeout   = (state_q == S_TIMEOUT);
            end
            default: outs = '0;
        endcase
    end

    assign phy_clk_en_o  = outs.clk_en;
    assign phy_power_o   = outs.power;
    assign phy_release_o = outs.release_n;
    assign ready_o       = outs.ready;
    assign timeout_o     = outs.timeout;
endmodule

// File: rtl/phy_pwrup_seq_chk.sv
module phy_pwrup_seq_chk #(
    parameter int STAT_W   = 4,
    parameter int LOCK_POS = 0,
    parameter int STOP_POS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              abort_i,
    input logic              tick_i,
    input logic [STAT_W-1:0] phy_status_i,
    input logic              phy_clk_en_o,
    input logic              phy_power_o,
    input logic              phy_release_o,
    input logic              ready_o,
    input logic              timeout_o
);
    // R4
    cumulative_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_release_o |-> phy_power_o) and (phy_power_o |-> phy_clk_en_o));

    // R7
    ready_timeout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && timeout_o));

    // R8
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !(phy_clk_en_o || phy_power_o || phy_release_o || ready_o || timeout_o));

    // R6
    ready_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(tick_i) && ($past(phy_status_i[LOCK_POS]) || $past(phy_status_i[STOP_POS])));

    // R10
    done_holds_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o || timeout_o) |-> (phy_clk_en_o && phy_power_o && phy_release_o));

    // R3
    power_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_power_o) |-> $past(phy_clk_en_o));
endmodule

bind phy_pwrup_seq phy_pwrup_seq_chk #(
    .STAT_W(STAT_W), .LOCK_POS(LOCK_POS), .STOP_POS(STOP_POS)
) u_chk (.*);

// File: tb/phy_pwrup_seq_test.sv
`timescale 1ns/1ps
module phy_pwrup_seq_test;
    localparam int STEP   = 2;
    localparam int SETTLE = 5;
    localparam int LIMIT  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, abort_i = 1'b0, tick_i = 1'b0;
    logic [3:0] phy_status_i = 4'd0;
    logic       phy_clk_en_o, phy_power_o, phy_release_o, ready_o, timeout_o;
    int         n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    phy_pwrup_seq #(.STAT_W(4), .LOCK_POS(0), .STOP_POS(2), .STEP_TICKS(STEP),
                    .SETTLE_TICKS(SETTLE), .POLL_LIMIT(LIMIT)) uut (.*);

    task automatic chk(input logic [4:0] act, input logic [4:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {phy_clk_en_o, phy_power_o, phy_release_o, ready_o, timeout_o};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    // Drive from start to the first cycle of polling; checks steps when deep is set
    task automatic to_poll(input bit deep);
        pulse_start();
        if (deep) chk(outs(), 5'b00000, "R2 clear");
        idle(1);
        if (deep) chk(outs(), 5'b10000, "R2 clk only");
        ticks(STEP);
        if (deep) chk(outs(), 5'b10000, "R3 not early");
        idle(1);
        if (deep) chk(outs(), 5'b11000, "R3 power");
        ticks(STEP);
        if (deep) chk(outs(), 5'b11000, "R4 not early");
        idle(1);
        if (deep) chk(outs(), 5'b11100, "R4 release");
        idle(1);
        if (deep) begin
            pulse_start();
            chk(outs(), 5'b11100, "R9 start ignored");
        end
        ticks(SETTLE);
        idle(1);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        chk(outs(), 5'b00000, "R1 in reset");
        rst_n = 1'b1;
        idle(2);
        chk(outs(), 5'b00000, "R1 after reset");

        // Detailed sequence; status hit present during settle
        phy_status_i = 4'b0001;
        to_poll(1'b1);
        chk(outs(), 5'b11100, "R5 no early sample");
        ticks(1);
        chk(outs(), 5'b11110, "R6 ready on lock");
        idle(3);
        chk(outs(), 5'b11110, "R10 ready holds");

        // Exhaustive status sweep, restart from READY/TIMEOUT each time
        for (int s = 0; s < 16; s++) begin
            logic hit;
            phy_status_i = 4'(s);
            hit = phy_status_i[0] | phy_status_i[2];
            to_poll(1'b0);
            ticks(LIMIT);
            chk(outs(), hit ? 5'b11110 : 5'b11101, $sformatf("R6 R7 status %0d", s));
        end

        // Hit arrival sweep over poll index
        for (int k = 0; k <= LIMIT; k++) begin
            phy_status_i = 4'b0000;
            to_poll(1'b0);
            ticks(k);
            if (k < LIMIT) chk(outs(), 5'b11100, "R7 not yet timed out");
            phy_status_i = 4'b0100;
            ticks(1);
            chk(outs(), (k < LIMIT) ? 5'b11110 : 5'b11101, $sformatf("R7 hit at poll %0d", k));
            idle(2);
            chk(outs(), (k < LIMIT) ? 5'b11110 : 5'b11101, "R10 result holds");
        end

        // Restart from TIMEOUT clears lines
        pulse_start();
        chk(outs(), 5'b00000, "R2 restart from timeout");

        // Abort mid-sequence, with start at the same time
        idle(1);
        ticks(STEP);
        idle(1);
        @(negedge clk) begin abort_i = 1'b1; start_i = 1'b1; end
        @(negedge clk) begin abort_i = 1'b0; start_i = 1'b0; end
        chk(outs(), 5'b00000, "R8 abort");
        idle(2);
        chk(outs(), 5'b00000, "R8 stays idle");

        // Abort from READY
        phy_status_i = 4'b0001;
        to_poll(1'b0);
        ticks(1);
        chk(outs(), 5'b11110, "R6 ready again");
        @(negedge clk) abort_i = 1'b1;
        @(negedge clk) abort_i = 1'b0;
        chk(outs(), 5'b00000, "R8 abort from ready");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule